// File: doc/BRIEF.md
# Privilege-Qualified Performance Counter Bank

This block holds four event counters. Each counter has a control register and a 32-bit count register. The control register picks one of eight incoming event pulses, marks the counter as privileged or user-level, and enables its overflow interrupt. The count register accumulates qualifying events. A global control register holds the run bit, which acts as the freeze gate, and the sticky overflow-pending bits. The global interrupt request is the OR of every pending bit whose interrupt enable is set.

Software reaches the registers through a simple read/write port. Each request carries the requester's privilege level, 0 to 3, with 0 the most privileged. Only level 0 may write. Read visibility depends on the counter's mode bit and on a secure-monitor status input. Counting depends on the run bit, on the counter's mode bit, and on two status inputs: one enables user counters and one enables privileged counters.

Address layout: `regAddr[3]` selects data space (1) or control space (0). `regAddr[2:0]` gives the register index. Counters sit at indices 4 to 7, so counter k uses index 4+k. In control space, index 0 is the global register; bit 0 is the run bit and bit 4+k is the overflow-pending bit of counter k. A counter control register holds the event select in bits [2:0], the overflow-interrupt enable in bit 5 and the privileged-mode bit in bit 6. Read data and the access-error pulse appear one cycle after the request. A write takes priority over a read presented in the same cycle.

Top module: `pmuCounterBank`

## Requirements
- R1: After reset every register reads as zero, the run bit is 0, and `irq`, `accessErr` and `regRdData` are 0.
- R2: A write at privilege level 0 updates the addressed register at the next clock edge. A write at any other level leaves every register unchanged and raises `accessErr` for one cycle, one cycle after the request.
- R3: A permitted read returns the addressed register on `regRdData` one cycle after the request. In every cycle without a permitted read, `regRdData` is 0.
- R4: A counter whose mode bit (control bit 6) is 1 is privileged. A read of its count register at a nonzero level returns 0 and pulses `accessErr`.
- R5: A user-level counter (mode bit 0) may be read at any level while `secureMon` is 0. While `secureMon` is 1, a read of it at a nonzero level returns 0 and pulses `accessErr`.
- R6: While the run bit is 1, a counter increments by one at each clock edge where its selected event input is 1 and its enable is 1. For a user counter the enable is `userEnable`; for a privileged counter it is `privEnable`. Events on inputs the counter does not select have no effect.
- R7: While the run bit (global bit 0) is 0, no counter changes except by a software write.
- R8: An increment from 0xFFFFFFFF wraps the count to 0 and sets that counter's pending bit (global bit 4+k). The pending bit stays set while further events occur.
- R9: A level-0 write to the global register clears each pending bit written as 1. `irq` is 1 exactly when some pending bit is set and that counter's interrupt enable (control bit 5) is also set.
- R10: When a count-register write and a qualifying event fall in the same cycle, the written value is stored and no increment applies.
- R11: Any read of control space (global or counter control) at a nonzero level returns 0 and pulses `accessErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request |
| regRdEn | input | 1 | Register read request |
| reqPriv | input | 2 | Privilege level of the requester (0 most privileged) |
| regAddr | input | 4 | Bit 3 selects data space, bits 2:0 give the index |
| regWrData | input | 32 | Write data |
| userEnable | input | 1 | Counting enable for user-level counters |
| privEnable | input | 1 | Counting enable for privileged counters |
| secureMon | input | 1 | Blocks nonzero-level reads of user counters |
| events | input | 8 | Event pulses; the counters select among them |
| regRdData | output | 32 | Read data, valid one cycle after a read |
| accessErr | output | 1 | One-cycle pulse on a refused access |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench checks refused writes by reading the target register back at level 0. A design that merely flags the error but still stores the data would show the new value. It checks privilege gating against both the mode bit and `secureMon`, so a design that ignores the mode bit and lets a privileged count leak to user level would return a nonzero value without an error.

It drives a counter across its maximum value. A design that loses the sticky bit, or that raises `irq` for a counter whose interrupt enable is clear, returns the wrong global-register value or a wrong `irq` level.

It also collides a count write with a live event. A design that lets the increment win would read back the written value plus one.

// File: rtl/pmuBankPkg.sv
package pmuBankPkg;
  localparam int NUM_CNT   = 4;
  localparam int CNT_W     = 32;
  localparam int NUM_EVT   = 8;
  localparam int BASE_IDX  = 4;
  localparam int IDX_W     = 3;
  localparam int PL_W      = 2;
  localparam int SEL_W     = $clog2(NUM_EVT);
  localparam int ADDR_W    = IDX_W + 1;
  localparam int SLOT_W    = $clog2(NUM_CNT);
  localparam int RUN_BIT   = 0;
  localparam int PEND_LSB  = 4;
  localparam int IE_BIT    = 5;
  localparam int MODE_BIT  = 6;

  typedef struct packed {
    logic               globalWr;
    logic [NUM_CNT-1:0] ctrlWr;
    logic [NUM_CNT-1:0] dataWr;
    logic               rdGo;
    logic               rdIsData;
    logic               rdGlobal;
    logic               rdHit;
    logic [SLOT_W-1:0]  rdIdx;
  } pmuStrobe_t;
endpackage

// File: rtl/pmuAccessCtrl.sv
module pmuAccessCtrl
  import pmuBankPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [PL_W-1:0]    reqPriv,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               secureMon,
  input  logic [NUM_CNT-1:0] cntPrivMode,
  output pmuStrobe_t         strobe,
  output logic               accessErr
);
  logic [IDX_W-1:0]  idx;
  logic              isData;
  logic              inBank;
  logic [SLOT_W-1:0] slot;
  logic              isPl0;
  logic              readOk;
  logic              errNext;

  always_comb begin
    idx     = addr[IDX_W-1:0];
    isData  = addr[IDX_W];
    inBank  = (int'(idx) >= BASE_IDX) && (int'(idx) < BASE_IDX + NUM_CNT);
    slot    = SLOT_W'(int'(idx) - BASE_IDX);
    isPl0   = (reqPriv == '0);
    readOk  = isPl0 || (isData && inBank && !cntPrivMode[slot] && !secureMon);
    strobe  = '0;
    errNext = 1'b0;
    if (wrEn) begin
      if (!isPl0) begin
        errNext = 1'b1;
      end else if (!isData && idx == '0) begin
        strobe.globalWr = 1'b1;
      end else if (inBank) begin
        if (isData) strobe.dataWr[slot] = 1'b1;
        else        strobe.ctrlWr[slot] = 1'b1;
      end
    end else if (rdEn) begin
      if (readOk) begin
        strobe.rdGo     = 1'b1;
        strobe.rdIsData = isData;
        strobe.rdGlobal = !isData && idx == '0;
        strobe.rdHit    = inBank;
        strobe.rdIdx    = slot;
      end else begin
        errNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) accessErr <= 1'b0;
    else       accessErr <= errNext;
  end

  // R2: refused write is flagged on the following cycle
  assert_wr_refused_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && reqPriv != '0) |=> accessErr);

  // R5: with secure monitor on, no nonzero-level read gets through
  assert_secure_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && secureMon && reqPriv != '0) |=> accessErr);
endmodule

// File: rtl/pmuCounterPath.sv
module pmuCounterPath
  import pmuBankPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  pmuStrobe_t         strobe,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [NUM_EVT-1:0] events,
  input  logic               userEnable,
  input  logic               privEnable,
  output logic [CNT_W-1:0]   rdData,
  output logic               irq,
  output logic [NUM_CNT-1:0] cntPrivMode
);
  logic                 runEn;
  logic [NUM_CNT-1:0]   pending;
  logic [NUM_CNT-1:0]   ovfIe;
  logic [SEL_W-1:0]     evtSel [NUM_CNT];
  logic [CNT_W-1:0]     count  [NUM_CNT];
  logic [NUM_CNT-1:0]   qual;
  logic [NUM_CNT-1:0]   wrap;
  logic [CNT_W-1:0]     rdNext;

  always_ff @(posedge clk) begin
    if (!rstN)                runEn <= 1'b0;
    else if (strobe.globalWr) runEn <= wrData[RUN_BIT];
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : gCnt
    always_comb begin
      qual[k] = runEn && events[evtSel[k]] &&
                (cntPrivMode[k] ? privEnable : userEnable);
      wrap[k] = qual[k] && (&count[k]) && !strobe.dataWr[k];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtSel[k]      <= '0;
        ovfIe[k]       <= 1'b0;
        cntPrivMode[k] <= 1'b0;
        count[k]       <= '0;
        pending[k]     <= 1'b0;
      end else begin
        if (strobe.ctrlWr[k]) begin
          evtSel[k]      <= wrData[SEL_W-1:0];
          ovfIe[k]       <= wrData[IE_BIT];
          cntPrivMode[k] <= wrData[MODE_BIT];
        end
        if (strobe.dataWr[k])  count[k] <= wrData;
        else if (qual[k])      count[k] <= count[k] + 1'b1;
        if (wrap[k])           pending[k] <= 1'b1;
        else if (strobe.globalWr && wrData[PEND_LSB + k]) pending[k] <= 1'b0;
      end
    end

    // R7: frozen bank holds every count unless software writes it
    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!runEn && !strobe.dataWr[k]) |=> $stable(count[k]));

    // R6: without a write a count moves by at most one per cycle
    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.dataWr[k] |=> (count[k] == $past(count[k]) ||
                             count[k] == $past(count[k]) + 32'd1));

    // R10: software write beats a simultaneous increment
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      strobe.dataWr[k] |=> count[k] == $past(wrData));

    // R8: pending stays set unless cleared by a global write
    assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
      (pending[k] && !strobe.globalWr) |=> pending[k]);
  end

  assign irq = |(pending & ovfIe);

  always_comb begin
    rdNext = '0;
    if (strobe.rdGo) begin
      if (strobe.rdGlobal) begin
        rdNext[RUN_BIT]               = runEn;
        rdNext[PEND_LSB +: NUM_CNT]   = pending;
      end else if (strobe.rdHit) begin
        if (strobe.rdIsData) begin
          rdNext = count[strobe.rdIdx];
        end else begin
          rdNext[SEL_W-1:0] = evtSel[strobe.rdIdx];
          rdNext[IE_BIT]    = ovfIe[strobe.rdIdx];
          rdNext[MODE_BIT]  = cntPrivMode[strobe.rdIdx];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/pmuCounterBank.sv
module pmuCounterBank
  import pmuBankPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [PL_W-1:0]    reqPriv,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CNT_W-1:0]   regWrData,
  input  logic               userEnable,
  input  logic               privEnable,
  input  logic               secureMon,
  input  logic [NUM_EVT-1:0] events,
  output logic [CNT_W-1:0]   regRdData,
  output logic               accessErr,
  output logic               irq
);
  pmuStrobe_t         strobe;
  logic [NUM_CNT-1:0] cntPrivMode;

  pmuAccessCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .rdEn(regRdEn),
    .reqPriv(reqPriv), .addr(regAddr), .secureMon(secureMon),
    .cntPrivMode(cntPrivMode), .strobe(strobe), .accessErr(accessErr)
  );

  pmuCounterPath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .events(events), .userEnable(userEnable), .privEnable(privEnable),
    .rdData(regRdData), .irq(irq), .cntPrivMode(cntPrivMode)
  );

  // R4: a refused access never returns data
  assert_blocked_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> regRdData == '0);
endmodule

// File: tb/pmuCounterBank_test.sv
module pmuCounterBank_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regRdEn, userEnable, privEnable, secureMon;
  logic [1:0]  reqPriv;
  logic [3:0]  regAddr;
  logic [31:0] regWrData;
  logic [7:0]  events;
  logic [31:0] regRdData;
  logic        accessErr, irq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  pmuCounterBank uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .reqPriv(reqPriv), .regAddr(regAddr), .regWrData(regWrData),
    .userEnable(userEnable), .privEnable(privEnable), .secureMon(secureMon),
    .events(events), .regRdData(regRdData), .accessErr(accessErr), .irq(irq)
  );

  // vector: isWr, pl[1:0], secure, addr[3:0], wdata[31:0], expRd[31:0], expErr
  localparam int NV = 16;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 4'h4, 32'h41,       32'h0,        1'b0},
    {1'b0, 2'd0, 1'b0, 4'h4, 32'h0,        32'h41,       1'b0},
    {1'b1, 2'd3, 1'b0, 4'h4, 32'h0,        32'h0,        1'b1},
    {1'b0, 2'd0, 1'b0, 4'h4, 32'h0,        32'h41,       1'b0},
    {1'b1, 2'd0, 1'b0, 4'hC, 32'hABCD,     32'h0,        1'b0},
    {1'b1, 2'd0, 1'b0, 4'h5, 32'h22,       32'h0,        1'b0},
    {1'b1, 2'd0, 1'b0, 4'hD, 32'h12345678, 32'h0,        1'b0},
    {1'b0, 2'd2, 1'b0, 4'hD, 32'h0,        32'h12345678, 1'b0},
    {1'b0, 2'd2, 1'b0, 4'hC, 32'h0,        32'h0,        1'b1},
    {1'b1, 2'd1, 1'b0, 4'hD, 32'hFFFF,     32'h0,        1'b1},
    {1'b0, 2'd0, 1'b0, 4'hD, 32'h0,        32'h12345678, 1'b0},
    {1'b0, 2'd1, 1'b0, 4'h5, 32'h0,        32'h0,        1'b1},
    {1'b0, 2'd1, 1'b1, 4'hD, 32'h0,        32'h0,        1'b1},
    {1'b0, 2'd0, 1'b1, 4'hC, 32'h0,        32'hABCD,     1'b0},
    {1'b0, 2'd0, 1'b0, 4'h0, 32'h0,        32'h0,        1'b0},
    {1'b0, 2'd3, 1'b0, 4'h0, 32'h0,        32'h0,        1'b1}
  };
  localparam logic [23:0] VTAG [NV] = '{
    "R2 ", "R2 ", "R2 ", "R2 ", "R2 ", "R2 ", "R2 ", "R5 ",
    "R4 ", "R2 ", "R3 ", "R11", "R5 ", "R3 ", "R3 ", "R11"
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic isWr, input logic [1:0] pl, input logic sec,
                    input logic [3:0] a, input logic [31:0] wd,
                    input logic [31:0] expRd, input logic expErr, input string tag);
    regWrEn = isWr; regRdEn = !isWr; reqPriv = pl; secureMon = sec;
    regAddr = a; regWrData = wd;
    @(negedge clk);
    check({tag, " data"}, regRdData, expRd);
    check({tag, " err"}, {31'b0, accessErr}, {31'b0, expErr});
    regWrEn = 1'b0; regRdEn = 1'b0; reqPriv = '0; secureMon = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] wd, input string tag);
    op(1'b1, 2'd0, 1'b0, a, wd, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] expRd, input string tag);
    op(1'b0, 2'd0, 1'b0, a, 32'h0, expRd, 1'b0, tag);
  endtask

  task automatic pulse(input logic [7:0] ev, input logic ue, input logic pe, input int n);
    events = ev; userEnable = ue; privEnable = pe;
    repeat (n) @(negedge clk);
    events = '0; userEnable = 1'b0; privEnable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; reqPriv = '0; regAddr = '0;
    regWrData = '0; userEnable = 0; privEnable = 0; secureMon = 0; events = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rd idle", regRdData, 32'h0);
    check("R1 err idle", {31'b0, accessErr}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'h0, 32'h0, "R1 global");
    rd(4'hF, 32'h0, "R1 data7");

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][72], VEC[i][71:70], VEC[i][69], VEC[i][68:65], VEC[i][64:33],
         VEC[i][32:1], VEC[i][0], string'(VTAG[i]));
    end

    wr(4'h6, 32'h03, "R2 ctrl6");
    wr(4'h7, 32'h43, "R2 ctrl7");
    // R7: frozen bank ignores events
    pulse(8'hFF, 1'b1, 1'b1, 5);
    rd(4'hE, 32'h0, "R7 data6 frozen");
    rd(4'hC, 32'hABCD, "R7 data4 frozen");

    wr(4'h0, 32'h1, "R2 run");
    pulse(8'h08, 1'b1, 1'b0, 4);
    rd(4'hE, 32'h4, "R6 user counts");
    rd(4'hF, 32'h0, "R6 priv idle");
    pulse(8'h08, 1'b0, 1'b1, 4);
    rd(4'hE, 32'h4, "R6 user idle");
    rd(4'hF, 32'h4, "R6 priv counts");
    pulse(8'h01, 1'b1, 1'b1, 3);
    rd(4'hE, 32'h4, "R6 unselected");

    // R8/R9: overflow on counter 5 with interrupt enabled
    wr(4'hD, 32'hFFFFFFFE, "R2 preload5");
    pulse(8'h04, 1'b1, 1'b0, 2);
    check("R9 irq set", {31'b0, irq}, 32'h1);
    rd(4'hD, 32'h0, "R8 wrap");
    rd(4'h0, 32'h21, "R8 pending");
    pulse(8'h04, 1'b1, 1'b0, 1);
    rd(4'h0, 32'h21, "R8 sticky");
    rd(4'hD, 32'h1, "R8 after wrap");
    wr(4'h0, 32'h21, "R9 clear");
    check("R9 irq clear", {31'b0, irq}, 32'h0);
    rd(4'h0, 32'h01, "R9 cleared");

    // R9: overflow without interrupt enable
    wr(4'hE, 32'hFFFFFFFF, "R2 preload6");
    pulse(8'h08, 1'b1, 1'b0, 1);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    rd(4'h0, 32'h41, "R8 pending6");
    wr(4'h0, 32'h41, "R9 clear6");
    rd(4'h0, 32'h01, "R9 cleared6");

    // R10: write collides with a live event
    events = 8'h08; userEnable = 1'b1;
    wr(4'hE, 32'h100, "R10 collide");
    events = '0; userEnable = 1'b0;
    rd(4'hE, 32'h100, "R10 write wins");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule